// File: doc/BRIEF.md
# Floating-Point NaN-Boxing Register File

This block connects a floating-point register array of width FLEN to datapaths that work on narrower formats. When a value is written in a format narrower than FLEN, the bits above the value are filled with ones, so the stored word looks like a quiet NaN at full width. When a word is read in a narrower format, the block checks that every bit above that format is one. If so, it returns the low bits. If not, it returns the canonical quiet NaN of the requested format.

The block holds a register array with one synchronous write port and two asynchronous read ports. Every port has its own format select. The boxing and unboxing logic between the ports and the array is combinational. A format wider than FLEN is flagged on the port that asked for it and has no effect on the array. Reset clears every entry to zero. A full-width read of a cleared entry therefore returns zero, and a narrower read returns the canonical NaN.

Top module: `fp_box_regfile`

## Requirements
- R1: A legal write stores a word whose bits at and above the format width w are all ones and whose low w bits are the low w bits of `wr_data`. Bits of `wr_data` at and above w are ignored.
- R2: A legal read of width w below FLEN, whose entry has all ones in bits FLEN-1..w, returns the entry's low w bits in the low w bits of the read data. The read data bits at and above w are zero.
- R3: A legal read of width w below FLEN, whose entry has any zero in bits FLEN-1..w, returns the canonical NaN of that width: 0x7E00 for 16, 0x7FC00000 for 32, 0x7FF8000000000000 for 64. For 128 it is sign 0, fifteen exponent ones, a leading significand one and zeros below.
- R4: When the format width equals FLEN, writes store `wr_data` unchanged and reads return the entry unchanged.
- R5: Format codes are 2'b00 = 16 bits, 2'b01 = 32, 2'b10 = 64 and 2'b11 = 128. `wr_illegal`, `rd0_illegal` and `rd1_illegal` are high, combinationally, exactly when the width selected on that port exceeds FLEN.
- R6: A write with an illegal format leaves the array unchanged. A read with an illegal format returns all zeros.
- R7: An entry is updated on the rising clock edge when `wr_en` is high and the format is legal. Reads are asynchronous: a read of the address being written shows the old value until that edge. Nothing changes while `wr_en` is low.
- R8: Reset clears every entry of the NREG (default 32) entry array to zero.
- R9: The two read ports decode address and format independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(NREG) | Write entry index |
| wr_fmt | input | 2 | Write format code |
| wr_data | input | FLEN | Write value, narrow formats in the low bits |
| wr_illegal | output | 1 | Write format wider than FLEN |
| rd0_addr | input | $clog2(NREG) | Read port 0 entry index |
| rd0_fmt | input | 2 | Read port 0 format code |
| rd0_data | output | FLEN | Read port 0 value, zero above the format width |
| rd0_illegal | output | 1 | Read port 0 format wider than FLEN |
| rd1_addr | input | $clog2(NREG) | Read port 1 entry index |
| rd1_fmt | input | 2 | Read port 1 format code |
| rd1_data | output | FLEN | Read port 1 value, zero above the format width |
| rd1_illegal | output | 1 | Read port 1 format wider than FLEN |

## Verification
Every entry is written once with a distinct arithmetic pattern, in a format that rotates through the legal ones. Each entry is then read back on both ports in every format. This separates a correct box-then-unbox round trip from a mix-up of widths or ports. A second sweep writes full-width words of all ones, each with a single zero walked across bits 16 to 63, and reads them narrow. This shows that the all-ones test covers exactly the bits above the requested format, since only a zero above that width must turn the result into the canonical NaN. Further cases cover illegal formats, writes held off by a low enable, a read of the entry being written in the same cycle, and the cleared state after reset.

// File: rtl/fp_box_pkg.sv
package fp_box_pkg;

  localparam int FMT_W = 2;
  localparam int MAX_W = 128;

  // Width in bits selected by a 2-bit format code (16, 32, 64, 128).
  function automatic int fmt_bits(input logic [FMT_W-1:0] f);
    return 16 << f;
  endfunction

  function automatic int exp_bits(input int w);
    case (w)
      16:      return 5;
      32:      return 8;
      64:      return 11;
      default: return 15;
    endcase
  endfunction

  // Canonical quiet NaN of width w, right-aligned: sign clear,
  // exponent all ones, top significand bit set, rest clear.
  function automatic logic [MAX_W-1:0] canon_nan(input int w);
    logic [MAX_W-1:0] v;
    int lo;
    lo = w - 2 - exp_bits(w);
    for (int i = 0; i < MAX_W; i++) begin
      v[i] = (i >= lo) && (i <= w - 2);
    end
    return v;
  endfunction

endpackage

// File: rtl/fp_box_rst_sync.sv
module fp_box_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fp_box_boxer.sv
module fp_box_boxer
  import fp_box_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FMT_W-1:0] fmt,
  input  logic [FLEN-1:0]  data,
  output logic [FLEN-1:0]  boxed,
  output logic             illegal
);
  int w;

  always_comb begin
    w       = fmt_bits(fmt);
    illegal = (w > FLEN);
    for (int i = 0; i < FLEN; i++) begin
      boxed[i] = (i < w) ? data[i] : 1'b1;
    end
  end
endmodule

// File: rtl/fp_box_unboxer.sv
module fp_box_unboxer
  import fp_box_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FMT_W-1:0] fmt,
  input  logic [FLEN-1:0]  word,
  output logic [FLEN-1:0]  value,
  output logic             illegal
);
  int               w;
  logic             upper_ok;
  logic [MAX_W-1:0] nan_v;

  always_comb begin
    w        = fmt_bits(fmt);
    illegal  = (w > FLEN);
    nan_v    = canon_nan(w);
    upper_ok = 1'b1;
    for (int i = 0; i < FLEN; i++) begin
      if (i >= w) upper_ok = upper_ok & word[i];
    end
    for (int i = 0; i < FLEN; i++) begin
      if (illegal || i >= w) value[i] = 1'b0;
      else if (upper_ok)     value[i] = word[i];
      else                   value[i] = nan_v[i];
    end
  end
endmodule

// File: rtl/fp_box_array.sv
module fp_box_array #(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [FLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr0,
  output logic [FLEN-1:0] rdata0,
  input  logic [AW-1:0]   raddr1,
  output logic [FLEN-1:0] rdata1
);
  logic [FLEN-1:0] mem_q [NREG];
  logic [NREG-1:0] ent_en;

  always_comb begin
    for (int e = 0; e < NREG; e++) begin
      ent_en[e] = we && (waddr == AW'(e));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [FLEN-1:0] ent_d;
    always_comb begin
      ent_d = ent_en[g] ? wdata : mem_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= ent_d;
    end
  end

  assign rdata0 = mem_q[raddr0];
  assign rdata1 = mem_q[raddr1];
endmodule

// File: rtl/fp_box_regfile.sv
module fp_box_regfile
  import fp_box_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_fmt,
  input  logic [FLEN-1:0] wr_data,
  output logic            wr_illegal,
  input  logic [AW-1:0]   rd0_addr,
  input  logic [1:0]      rd0_fmt,
  output logic [FLEN-1:0] rd0_data,
  output logic            rd0_illegal,
  input  logic [AW-1:0]   rd1_addr,
  input  logic [1:0]      rd1_fmt,
  output logic [FLEN-1:0] rd1_data,
  output logic            rd1_illegal
);
  logic            rst_sync_n;
  logic [FLEN-1:0] boxed;
  logic            we_ok;
  logic [FLEN-1:0] raw0;
  logic [FLEN-1:0] raw1;

  fp_box_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fp_box_boxer #(.FLEN(FLEN)) box_i (
    .fmt(wr_fmt), .data(wr_data), .boxed(boxed), .illegal(wr_illegal)
  );

  assign we_ok = wr_en && !wr_illegal;

  fp_box_array #(.FLEN(FLEN), .NREG(NREG)) arr_i (
    .clk(clk), .rst_n(rst_sync_n), .we(we_ok), .waddr(wr_addr),
    .wdata(boxed), .raddr0(rd0_addr), .rdata0(raw0),
    .raddr1(rd1_addr), .rdata1(raw1)
  );

  fp_box_unboxer #(.FLEN(FLEN)) unbox0_i (
    .fmt(rd0_fmt), .word(raw0), .value(rd0_data), .illegal(rd0_illegal)
  );

  fp_box_unboxer #(.FLEN(FLEN)) unbox1_i (
    .fmt(rd1_fmt), .word(raw1), .value(rd1_data), .illegal(rd1_illegal)
  );
endmodule

// File: rtl/fp_box_regfile_chk.sv
module fp_box_regfile_chk
  import fp_box_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [1:0]      wr_fmt,
  input logic            wr_illegal,
  input logic [AW-1:0]   rd0_addr,
  input logic [1:0]      rd0_fmt,
  input logic [FLEN-1:0] rd0_data,
  input logic            rd0_illegal
);
  AST_WR_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal == (fmt_bits(wr_fmt) > FLEN)); // R5

  AST_RD_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_illegal |-> (rd0_data == '0)); // R6

  AST_RD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd0_illegal && fmt_bits(rd0_fmt) < FLEN) |-> ((rd0_data >> fmt_bits(rd0_fmt)) == '0)); // R2

  AST_RD_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(wr_en) || $past(wr_illegal) || ($past(wr_addr) != rd0_addr))
     && $stable(rd0_addr) && $stable(rd0_fmt)) |-> $stable(rd0_data)); // R7
endmodule

bind fp_box_regfile fp_box_regfile_chk #(.FLEN(FLEN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_fmt(wr_fmt), .wr_illegal(wr_illegal), .rd0_addr(rd0_addr),
  .rd0_fmt(rd0_fmt), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal)
);

// File: tb/fp_box_regfile_tb_top.sv
`timescale 1ns/1ps
module fp_box_regfile_tb_top;
  localparam int FLEN = 64;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [4:0] wr_addr;
  logic [1:0] wr_fmt;
  logic [63:0] wr_data;
  logic wr_illegal;
  logic [4:0] rd0_addr, rd1_addr;
  logic [1:0] rd0_fmt, rd1_fmt;
  logic [63:0] rd0_data, rd1_data;
  logic rd0_illegal, rd1_illegal;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] model [NREG];

  always #4 clk = ~clk;

  fp_box_regfile #(.FLEN(FLEN), .NREG(NREG)) dut_i (.*);

  function automatic logic [63:0] lowmask(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] box_ref(input logic [1:0] f, input logic [63:0] d);
    int w = 16 << f;
    return (d & lowmask(w)) | ~lowmask(w);
  endfunction

  function automatic logic [63:0] unbox_ref(input logic [1:0] f, input logic [63:0] word);
    int w = 16 << f;
    if (w > 64) return '0;
    if (w == 64) return word;
    if ((word | lowmask(w)) == '1) return word & lowmask(w);
    return (f == 2'd0) ? 64'h7E00 : 64'h7FC0_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [1:0] f, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_fmt = f; wr_data = d;
    #1 chk("R5 wr flag", 64'(wr_illegal), 64'((16 << f) > 64));
    @(negedge clk);
    wr_en = 0;
    if ((16 << f) <= 64) model[a] = box_ref(f, d);
  endtask

  task automatic rd_all(input logic [4:0] a0, input logic [4:0] a1, input string req);
    for (int f = 0; f < 4; f++) begin
      rd0_addr = a0; rd1_addr = a1;
      rd0_fmt = 2'(f); rd1_fmt = 2'(3 - f);
      #1;
      chk(req, rd0_data, unbox_ref(2'(f), model[a0]));
      chk({req, " R9 port1"}, rd1_data, unbox_ref(2'(3 - f), model[a1]));
      chk("R5 rd flag", 64'(rd0_illegal), 64'(f == 3));
    end
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_fmt = 0; wr_data = 0;
    rd0_addr = 0; rd1_addr = 0; rd0_fmt = 0; rd1_fmt = 0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R8: cleared entries; full width reads zero, narrow reads canonical NaN (R3)
    for (int a = 0; a < NREG; a++) begin
      rd0_addr = 5'(a); rd0_fmt = 2'd2; rd1_addr = 5'(a); rd1_fmt = 2'd0;
      #1;
      chk("R8 reset full", rd0_data, 64'h0);
      chk("R8 R3 reset half", rd1_data, 64'h7E00);
      rd1_fmt = 2'd1;
      #1 chk("R8 R3 reset single", rd1_data, 64'h7FC0_0000);
    end

    // R1 R2: write every entry with a rotating format and a patterned value
    for (int a = 0; a < NREG; a++) begin
      logic [63:0] d;
      d = (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
      do_write(5'(a), 2'(a % 3), d);
      rd0_addr = 5'(a); rd0_fmt = 2'(a % 3);
      #1 chk("R2 round trip", rd0_data, d & lowmask(16 << (a % 3)));
      rd0_fmt = 2'd2;
      #1 chk("R1 stored box", rd0_data, box_ref(2'(a % 3), d));
    end
    for (int a = 0; a < NREG; a++) rd_all(5'(a), 5'(NREG - 1 - a), "R2 R3 sweep");

    // R3: a single zero walked through the upper part of a full-width word
    for (int k = 16; k < 64; k++) begin
      logic [63:0] d;
      d = ~(64'd1 << k);
      do_write(5'd7, 2'd2, d);
      rd0_addr = 5'd7; rd0_fmt = 2'd0; rd1_addr = 5'd7; rd1_fmt = 2'd1;
      #1;
      chk("R3 half walk", rd0_data, 64'h7E00);
      chk("R3 single walk", rd1_data, (k < 32) ? (d & 64'hFFFF_FFFF) : 64'h7FC0_0000);
    end

    // R4: full-width pass-through
    do_write(5'd9, 2'd2, 64'h0000_1234_8000_0001);
    rd0_addr = 5'd9; rd0_fmt = 2'd2;
    #1 chk("R4 pass", rd0_data, 64'h0000_1234_8000_0001);
    rd0_fmt = 2'd1;
    #1 chk("R3 narrow of wide", rd0_data, 64'h7FC0_0000);

    // R6: illegal write ignored, illegal read zero
    do_write(5'd9, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd0_fmt = 2'd2;
    #1 chk("R6 illegal write kept", rd0_data, 64'h0000_1234_8000_0001);
    rd0_fmt = 2'd3;
    #1 chk("R6 illegal read zero", rd0_data, 64'h0);
    chk("R5 rd illegal", 64'(rd0_illegal), 64'd1);

    // R7: enable low, and same-cycle read shows the old value
    @(negedge clk);
    wr_en = 0; wr_addr = 5'd9; wr_fmt = 2'd2; wr_data = 64'hDEAD_BEEF_0000_0000;
    @(negedge clk);
    rd0_fmt = 2'd2;
    #1 chk("R7 no enable", rd0_data, 64'h0000_1234_8000_0001);
    wr_en = 1;
    #1 chk("R7 old before edge", rd0_data, 64'h0000_1234_8000_0001);
    @(negedge clk);
    wr_en = 0;
    #1 chk("R7 new after edge", rd0_data, 64'hDEAD_BEEF_0000_0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule